// File: doc/BRIEF.md
# Standby Entry and Wake Sequencer

This block sequences a small microcontroller into and out of its deepest clock-stopped standby. The CPU pulses a wait strobe. If the standby-select control bit is 1 and the data-transfer engine is idle, the sequencer spends one cycle gating the CPU and peripheral clocks. It then drops the oscillator enable and holds there. The block has no reset or clear output, so registers, RAM, peripheral state and port levels in the gated domains stay as they were.

While in standby, the block picks the count enable for the independent watchdog from the watchdog start mode. In auto-start mode the boot-option stop bit decides, and in register-start mode the register stop bit decides. An interrupt wakes the part only when it is pending, enabled, routed to the CPU, and has a priority strictly above the current 4-bit mask level. On wake the oscillator restarts first. The clocks come back after a programmable settling interval.

Top module: `stby_ctrl`

## Requirements
- R1: In state RUN, `wait_strobe`=1 together with `stby_sel`=1 and `dma_busy`=0 moves the controller to ENTER on the next cycle. With `stby_sel`=0 it stays in RUN. A wait strobe outside RUN has no effect.
- R2: `cpu_clk_en` and `per_clk_en` are 1 only in RUN. `osc_en` is 0 only in STANDBY.
- R3: Outside STANDBY, `wdt_cnt_en` is 1. In STANDBY with `wdt_auto`=1 it equals the inverse of `wdt_boot_stop`. With `wdt_auto`=0 it equals the inverse of `wdt_reg_stop`.
- R4: `ie_set_pulse` is 1 for exactly the one cycle spent in ENTER.
- R5: Interrupt source i is a wake source only when its pending, enable and CPU-destination bits are all 1 and its 4-bit priority field `irq_prio[4i+3:4i]` is strictly greater than `mask_lvl`. A priority equal to the mask does not wake.
- R6: A standby request (R1 conditions) made while `dma_busy`=1 is refused. The controller stays in RUN and `entry_err` is 1 for one cycle, the cycle after the request.
- R7: A wake source in STANDBY moves the controller to OSC_SETTLE on the next cycle. There `osc_en` is 1 and both clock enables are still 0. Wake sources in RUN, ENTER-only timing aside, are ignored.
- R8: OSC_SETTLE lasts `settle_cnt` cycles, or 1 cycle when `settle_cnt`=0. The value is taken when OSC_SETTLE is entered, and the state is followed by RUN.
- R9: A wake source present during the ENTER cycle is remembered, so the controller leaves STANDBY after a single cycle there even if the source is gone.
- R10: While `rst_n`=0 the controller is in RUN with `osc_en`, `cpu_clk_en`, `per_clk_en` and `wdt_cnt_en` at 1, and `ie_set_pulse` and `entry_err` at 0.
- R11: `pm_state` reports the state with the encoding RUN=0, ENTER=1, STANDBY=2, OSC_SETTLE=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wait_strobe | input | 1 | One-cycle wait-instruction strobe from the CPU |
| stby_sel | input | 1 | Selects deep standby for the wait instruction |
| dma_busy | input | 1 | Data-transfer engine start bit still set |
| irq_pend | input | NUM_IRQ | Pending interrupt requests |
| irq_en | input | NUM_IRQ | Per-source interrupt enable |
| irq_to_cpu | input | NUM_IRQ | Source routed to the CPU |
| irq_prio | input | NUM_IRQ*PRIO_W | Packed per-source priorities |
| mask_lvl | input | PRIO_W | Current CPU priority mask level |
| wdt_auto | input | 1 | Watchdog start mode: 1 auto-start, 0 register-start |
| wdt_boot_stop | input | 1 | Boot-option stop-in-standby bit |
| wdt_reg_stop | input | 1 | Register stop-in-standby bit |
| settle_cnt | input | SETTLE_W | Oscillator settling length in cycles |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| wdt_cnt_en | output | 1 | Watchdog count enable |
| ie_set_pulse | output | 1 | Sets the CPU global interrupt-enable flag |
| entry_err | output | 1 | Refused standby request |
| pm_state | output | 2 | Current state |

## Verification
The embedded assertions check the clock and oscillator gating in STANDBY and OSC_SETTLE on every cycle. They also check that the entry and refusal transitions follow a request, that the interrupt-enable pulse lasts a single cycle, that a wake seen in ENTER forces the exit from STANDBY, and that no source wakes the part when the mask is at its maximum. Other behaviours need the bench's stimulus and its cycle-level model. These are the settling length for each sampled `settle_cnt`, the strict priority comparison at equality, the watchdog enable choice across start modes and stop bits, and the exact cycle in which each state is reached.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {
    PM_RUN    = 2'd0,
    PM_ENTER  = 2'd1,
    PM_STBY   = 2'd2,
    PM_SETTLE = 2'd3
  } pm_state_e;
endpackage

// File: rtl/stby_wake_eval.sv
module stby_wake_eval #(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 4
) (
  input  logic [NUM_IRQ-1:0]        pend_i,
  input  logic [NUM_IRQ-1:0]        en_i,
  input  logic [NUM_IRQ-1:0]        cpu_dest_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]         mask_i,
  output logic                      wake_o
);
  logic [NUM_IRQ-1:0] qual;

  for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_src
    logic [PRIO_W-1:0] prio_s;
    assign prio_s    = prio_i[gi*PRIO_W +: PRIO_W];
    assign qual[gi]  = pend_i[gi] & en_i[gi] & cpu_dest_i[gi] & (prio_s > mask_i);
  end

  assign wake_o = |qual;

  // R5: nothing can exceed the highest mask level
  always_comb begin
    if (mask_i == '1) begin
      a_r5_max_mask: assert (!wake_o);
    end
  end
endmodule

// File: rtl/stby_wdt_sel.sv
module stby_wdt_sel (
  input  logic in_stby_i,
  input  logic auto_mode_i,
  input  logic boot_stop_i,
  input  logic reg_stop_i,
  output logic cnt_en_o
);
  logic stop_sel;

  assign stop_sel = auto_mode_i ? boot_stop_i : reg_stop_i;
  assign cnt_en_o = ~(in_stby_i & stop_sel);

  // R3: both stop bits clear never halt counting
  always_comb begin
    if (!boot_stop_i && !reg_stop_i) begin
      a_r3_no_stop_counts: assert (cnt_en_o);
    end
  end
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wait_i,
  input  logic                sel_i,
  input  logic                dma_busy_i,
  input  logic                wake_i,
  input  logic [SETTLE_W-1:0] settle_i,
  output pm_state_e           state_o,
  output logic                err_o
);
  localparam logic [SETTLE_W-1:0] CNT_ONE = SETTLE_W'(1);

  pm_state_e           state_q, state_d;
  logic [SETTLE_W-1:0] cnt_q, cnt_d;
  logic                cnt_we;
  logic                pend_q, pend_d;
  logic                err_q, err_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_we  = 1'b0;
    pend_d  = pend_q;
    err_d   = 1'b0;
    unique case (state_q)
      PM_RUN: begin
        pend_d = 1'b0;
        if (wait_i && sel_i) begin
          if (dma_busy_i) err_d   = 1'b1;
          else            state_d = PM_ENTER;
        end
      end
      PM_ENTER: begin
        state_d = PM_STBY;
        pend_d  = wake_i;
      end
      PM_STBY: begin
        if (wake_i || pend_q) begin
          state_d = PM_SETTLE;
          cnt_d   = settle_i;
          cnt_we  = 1'b1;
          pend_d  = 1'b0;
        end
      end
      PM_SETTLE: begin
        if (cnt_q <= CNT_ONE) begin
          state_d = PM_RUN;
        end else begin
          cnt_d  = cnt_q - CNT_ONE;
          cnt_we = 1'b1;
        end
      end
      default: state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_RUN;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign state_o = state_q;
  assign err_o   = err_q;

  // R9: a wake seen in ENTER is held into STANDBY
  a_r9_latch_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_ENTER && wake_i) |=> (state_q == PM_STBY && pend_q));
  // R9: a held wake forces the exit
  a_r9_latch_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_STBY && pend_q) |=> (state_q == PM_SETTLE));
  // R8: settling always returns to RUN, never straight to standby
  a_r8_settle_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_SETTLE) |=> (state_q == PM_SETTLE || state_q == PM_RUN));
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
#(
  parameter int NUM_IRQ  = 8,
  parameter int PRIO_W   = 4,
  parameter int SETTLE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wait_strobe,
  input  logic                      stby_sel,
  input  logic                      dma_busy,
  input  logic [NUM_IRQ-1:0]        irq_pend,
  input  logic [NUM_IRQ-1:0]        irq_en,
  input  logic [NUM_IRQ-1:0]        irq_to_cpu,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0]         mask_lvl,
  input  logic                      wdt_auto,
  input  logic                      wdt_boot_stop,
  input  logic                      wdt_reg_stop,
  input  logic [SETTLE_W-1:0]       settle_cnt,
  output logic                      osc_en,
  output logic                      cpu_clk_en,
  output logic                      per_clk_en,
  output logic                      wdt_cnt_en,
  output logic                      ie_set_pulse,
  output logic                      entry_err,
  output logic [1:0]                pm_state
);
  pm_state_e st;
  logic      wake;

  stby_wake_eval #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_wake (
    .pend_i     (irq_pend),
    .en_i       (irq_en),
    .cpu_dest_i (irq_to_cpu),
    .prio_i     (irq_prio),
    .mask_i     (mask_lvl),
    .wake_o     (wake)
  );

  stby_fsm #(.SETTLE_W(SETTLE_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wait_i     (wait_strobe),
    .sel_i      (stby_sel),
    .dma_busy_i (dma_busy),
    .wake_i     (wake),
    .settle_i   (settle_cnt),
    .state_o    (st),
    .err_o      (entry_err)
  );

  stby_wdt_sel u_wdt (
    .in_stby_i   (st == PM_STBY),
    .auto_mode_i (wdt_auto),
    .boot_stop_i (wdt_boot_stop),
    .reg_stop_i  (wdt_reg_stop),
    .cnt_en_o    (wdt_cnt_en)
  );

  assign osc_en       = (st != PM_STBY);
  assign cpu_clk_en   = (st == PM_RUN);
  assign per_clk_en   = (st == PM_RUN);
  assign ie_set_pulse = (st == PM_ENTER);
  assign pm_state     = st;

  // R1: an accepted request enters the gating cycle
  a_r1_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd0 && wait_strobe && stby_sel && !dma_busy) |=> (pm_state == 2'd1));
  // R2: standby stops every clock and the oscillator
  a_r2_stby_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd2) |-> (!osc_en && !cpu_clk_en && !per_clk_en));
  // R4: the interrupt-enable pulse is one cycle wide
  a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    ie_set_pulse |=> !ie_set_pulse);
  // R6: a refused request flags an error and stays in RUN
  a_r6_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd0 && wait_strobe && stby_sel && dma_busy) |=> (entry_err && pm_state == 2'd0));
  // R7: settling runs the oscillator with clocks still gated
  a_r7_settle_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd3) |-> (osc_en && !cpu_clk_en && !per_clk_en));
endmodule

// File: tb/test_stby_ctrl.sv
module test_stby_ctrl;
  localparam int NI = 8;
  localparam int PW = 4;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic wait_s, sel, dma;
  logic [NI-1:0] pend, en, dest;
  logic [NI*PW-1:0] prio;
  logic [PW-1:0] mask;
  logic wauto, wboot, wreg;
  logic [SW-1:0] settle;
  logic osc_en, cpu_clk_en, per_clk_en, wdt_cnt_en, ie_set_pulse, entry_err;
  logic [1:0] pm_state;

  int errors = 0;
  int checks = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  stby_ctrl #(.NUM_IRQ(NI), .PRIO_W(PW), .SETTLE_W(SW)) i_stby_ctrl (
    .clk(clk), .rst_n(rst_n), .wait_strobe(wait_s), .stby_sel(sel), .dma_busy(dma),
    .irq_pend(pend), .irq_en(en), .irq_to_cpu(dest), .irq_prio(prio), .mask_lvl(mask),
    .wdt_auto(wauto), .wdt_boot_stop(wboot), .wdt_reg_stop(wreg), .settle_cnt(settle),
    .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .wdt_cnt_en(wdt_cnt_en), .ie_set_pulse(ie_set_pulse), .entry_err(entry_err),
    .pm_state(pm_state)
  );

  function automatic bit wake_f();
    for (int i = 0; i < NI; i++)
      if (pend[i] && en[i] && dest[i] && (prio[i*PW +: PW] > mask)) return 1'b1;
    return 1'b0;
  endfunction

  // cycle model built from the requirements
  int m_state;
  int m_cnt;
  bit m_pend, m_err;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state <= 0; m_cnt <= 0; m_pend <= 1'b0; m_err <= 1'b0;
    end else begin
      m_err <= 1'b0;
      case (m_state)
        0: begin
          m_pend <= 1'b0;
          if (wait_s && sel) begin
            if (dma) m_err <= 1'b1; else m_state <= 1;
          end
        end
        1: begin m_state <= 2; m_pend <= wake_f(); end
        2: if (wake_f() || m_pend) begin m_state <= 3; m_cnt <= int'(settle); m_pend <= 1'b0; end
        default: if (m_cnt <= 1) m_state <= 0; else m_cnt <= m_cnt - 1;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      bit e_wdt;
      e_wdt = (m_state == 2) ? !(wauto ? wboot : wreg) : 1'b1;
      chk(pm_state == m_state[1:0], "R11/R1 state", pm_state, m_state);
      chk(osc_en == (m_state != 2), "R2 osc_en", osc_en, m_state != 2);
      chk(cpu_clk_en == (m_state == 0), "R2 cpu_clk_en", cpu_clk_en, m_state == 0);
      chk(per_clk_en == (m_state == 0), "R2 per_clk_en", per_clk_en, m_state == 0);
      chk(wdt_cnt_en == e_wdt, "R3 wdt_cnt_en", wdt_cnt_en, e_wdt);
      chk(ie_set_pulse == (m_state == 1), "R4 ie_set_pulse", ie_set_pulse, m_state == 1);
      chk(entry_err == m_err, "R6 entry_err", entry_err, m_err);
    end
  end

  task automatic idle_in();
    wait_s = 0; sel = 0; dma = 0; pend = '0; en = '1; dest = '1;
    prio = '0; mask = 4'd3; wauto = 1; wboot = 0; wreg = 0; settle = 8'd2;
  endtask

  // consume one cycle and check the state reached
  task automatic exp_st(input int e, input string tag);
    @(negedge clk);
    chk(pm_state == e[1:0], tag, pm_state, e);
    #1;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R10, R11: reset state
    chk(pm_state == 2'd0, "R11 reset state", pm_state, 0);
    chk(osc_en && cpu_clk_en && per_clk_en && wdt_cnt_en, "R10 reset enables",
        {osc_en, cpu_clk_en, per_clk_en, wdt_cnt_en}, 15);
    chk(!ie_set_pulse && !entry_err, "R10 reset pulses", {ie_set_pulse, entry_err}, 0);
    #1 rst_n = 1; cmp_on = 1;
    exp_st(0, "R10 run after release");

    // R1: select bit clear keeps RUN
    wait_s = 1; sel = 0; exp_st(0, "R1 sel=0 stays run");
    // R6: busy transfer engine refuses entry
    sel = 1; dma = 1; exp_st(0, "R6 refused stays run");
    chk(entry_err == 1'b1, "R6 entry_err pulse", entry_err, 1);
    wait_s = 0; dma = 0; exp_st(0, "R6 idle");
    chk(entry_err == 1'b0, "R6 err one cycle", entry_err, 0);

    // R1/R4/R2: normal entry
    wait_s = 1; exp_st(1, "R1 enter");
    chk(ie_set_pulse == 1'b1, "R4 pulse in enter", ie_set_pulse, 1);
    chk(osc_en && !cpu_clk_en, "R2 enter gating", {osc_en, cpu_clk_en}, 2);
    exp_st(2, "R1 standby reached");
    chk(!osc_en && !per_clk_en, "R2 standby gating", {osc_en, per_clk_en}, 0);
    exp_st(2, "R1 wait ignored in standby");
    wait_s = 0;
    // R3: watchdog mode choices
    wauto = 1; wboot = 1; wreg = 0; exp_st(2, "R3 hold");
    chk(wdt_cnt_en == 1'b0, "R3 auto boot stop", wdt_cnt_en, 0);
    wauto = 0; exp_st(2, "R3 hold");
    chk(wdt_cnt_en == 1'b1, "R3 reg mode no stop", wdt_cnt_en, 1);
    wreg = 1; exp_st(2, "R3 hold");
    chk(wdt_cnt_en == 1'b0, "R3 reg mode stop", wdt_cnt_en, 0);
    // R5: equal priority, disabled, not routed
    pend = 8'h04; prio = 32'h0000_0300; mask = 4'd3; exp_st(2, "R5 equal prio no wake");
    prio = 32'h0000_0400; en = 8'hFB; exp_st(2, "R5 disabled no wake");
    en = '1; dest = 8'hFB; exp_st(2, "R5 not to cpu no wake");
    // R7/R8: wake then settle for 3 cycles
    dest = '1; settle = 8'd3; exp_st(3, "R7 wake to settle");
    chk(osc_en && !cpu_clk_en, "R7 osc on clocks off", {osc_en, cpu_clk_en}, 2);
    pend = '0; settle = 8'd9;
    exp_st(3, "R8 settle 2"); exp_st(3, "R8 settle 3"); exp_st(0, "R8 back to run");
    // R9: wake only during ENTER, settle 0
    settle = 8'd0; wait_s = 1; sel = 1; exp_st(1, "R9 enter");
    wait_s = 0; pend = 8'h80; prio = 32'hF000_0000; exp_st(2, "R9 standby");
    pend = '0; exp_st(3, "R9 latched wake");
    exp_st(0, "R8 zero settle one cycle");
    // R7: wake in RUN ignored
    pend = 8'h80; exp_st(0, "R7 run ignores wake");

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      wait_s = ($urandom % 6) == 0;
      sel    = ($urandom % 4) != 0;
      dma    = ($urandom % 5) == 0;
      pend   = (($urandom % 10) < 7) ? '0 : NI'($urandom);
      en     = NI'($urandom);
      dest   = NI'($urandom);
      prio   = ($urandom);
      mask   = PW'($urandom);
      wauto  = 1'($urandom);
      wboot  = 1'($urandom);
      wreg   = 1'($urandom);
      settle = SW'($urandom % 6);
      @(negedge clk); #1;
    end
    idle_in();
    repeat (12) @(negedge clk);
    cmp_on = 0;
    summary();
  end
endmodule